// File: doc/BRIEF.md
# Compare-Match Timer with Reference Prescaler

This peripheral counts slow reference-clock ticks through a selectable prescaler into a 32-bit up-counter. On each prescaled count it compares the counter with a 32-bit compare constant. When the two are equal it latches a match flag. In one-shot mode the timer then stops and keeps its value. In free-running mode the counter returns to zero and counting goes on. An optional interrupt output follows the match flag while the interrupt is enabled.

Software drives the block through a word-addressed register bus with a combinational read path. The reference clock reaches the block as a single-cycle `ref_tick` pulse, synchronous to the system clock. A counter write is not applied at once. It is carried across to the reference side and takes effect two reference ticks after the write. A busy bit in the control/status register shows that the write is still pending, and software polls it before it reconfigures the timer. There is no streaming data path, so every pin is a plain control or status signal.

Top module: `match_timer`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: The run control is bit 5 of the start register (offset 0x00). Clearing it stops counting, and the counter holds its value while stopped.
- R3: While running, the counter increments by one per prescaled count. The divisor of `ref_tick` comes from control/status bits 2:0: code 0 divides by 1, 1 by 4, 2 by 8, 3 by 128, 4 by 256, 5 by 32, and 6 or 7 by 1. The prescaler restarts from zero whenever the timer is stopped.
- R4: On a prescaled count where the counter (offset 0x64) equals the compare constant (offset 0x68), the match flag at control/status bit 15 is set. In one-shot mode (control/status bit 8 = 0) the counter keeps its value and the run bit clears. So from a count of 0, the match comes on count number compare+1.
- R5: In free-running mode (control/status bit 8 = 1), a match clears the counter to 0 and the run bit stays set.
- R6: Writing the control/status register (offset 0x60) with bit 15 = 0 clears the match flag. Writing it with bit 15 = 1 leaves the flag unchanged. A match in the same cycle wins over a clear.
- R7: `irq` is high exactly while the match flag is set and the interrupt enable (control/status bit 4) is 1.
- R8: A counter write sets the busy bit (control/status bit 13). The new value is loaded, and the busy bit clears, on the second `ref_tick` after the write. Until then the counter neither counts nor changes.
- R9: A write to the compare constant takes effect at once and reads back unchanged. Reads at unused offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle pulse per reference-clock edge |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq | output | 1 | Match interrupt request |

## Verification
The assertions assume that `ref_tick` is a clean single-cycle strobe in the system clock domain. They also assume that bus writes are single-cycle strobes whose data is stable during that cycle. The bench keeps to these assumptions by driving every input on the falling edge and holding `ref_tick` high for exactly one cycle, with at least one idle cycle between pulses. The bench waits for the busy bit to clear before it reconfigures the timer, as software has to.

// File: rtl/mt_pkg.sv
package mt_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned PS_W   = 9;

  localparam logic [7:0] OFF_START = 8'h00;
  localparam logic [7:0] OFF_CSR   = 8'h60;
  localparam logic [7:0] OFF_COUNT = 8'h64;
  localparam logic [7:0] OFF_CMP   = 8'h68;

  localparam int unsigned BIT_RUN  = 5;
  localparam int unsigned BIT_FLAG = 15;
  localparam int unsigned BIT_BUSY = 13;
  localparam int unsigned BIT_FREE = 8;
  localparam int unsigned BIT_IE   = 4;

  typedef struct packed {
    logic       free_run;
    logic       irq_en;
    logic [2:0] clk_sel;
  } mt_cfg_t;

  function automatic logic [PS_W-1:0] div_of(input logic [2:0] sel);
    case (sel)
      3'd1:    div_of = PS_W'(4);
      3'd2:    div_of = PS_W'(8);
      3'd3:    div_of = PS_W'(128);
      3'd4:    div_of = PS_W'(256);
      3'd5:    div_of = PS_W'(32);
      default: div_of = PS_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/mt_prescaler.sv
module mt_prescaler
  import mt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_tick,
  input  logic       run,
  input  logic [2:0] clk_sel,
  output logic       cnt_pulse
);
  logic [PS_W-1:0] pcnt;
  logic [PS_W-1:0] last;

  assign last      = div_of(clk_sel) - PS_W'(1);
  assign cnt_pulse = run && ref_tick && (pcnt >= last);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) pcnt <= '0;
    else if (ref_tick) pcnt <= (pcnt >= last) ? '0 : pcnt + PS_W'(1);
  end

  a_r3_pulse_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_pulse |-> (ref_tick && run));
  a_r3_restart_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pcnt == '0));
endmodule

// File: rtl/mt_counter.sv
module mt_counter
  import mt_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ref_tick,
  input  logic         cnt_pulse,
  input  logic         free_run,
  input  logic         cnt_wr,
  input  logic         cmp_wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cmp,
  output logic         busy,
  output logic         match_evt
);
  logic [W-1:0] pend;
  logic         stage;

  assign match_evt = cnt_pulse && !busy && (cnt == cmp);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      cmp   <= '0;
      pend  <= '0;
      busy  <= 1'b0;
      stage <= 1'b0;
    end else begin
      if (cmp_wr) cmp <= wdata;
      if (cnt_wr) begin
        pend  <= wdata;
        busy  <= 1'b1;
        stage <= 1'b0;
      end else if (busy && ref_tick) begin
        if (stage) begin
          cnt   <= pend;
          busy  <= 1'b0;
          stage <= 1'b0;
        end else begin
          stage <= 1'b1;
        end
      end
      if (!busy && cnt_pulse) begin
        if (cnt == cmp) begin
          if (free_run) cnt <= '0;
        end else begin
          cnt <= cnt + W'(1);
        end
      end
    end
  end

  a_r8_busy_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(ref_tick && stage)) |=> $stable(cnt));
  a_r8_load_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ref_tick && stage && !cnt_wr) |=> !busy);
  a_r5_free_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && free_run) |=> (cnt == '0));
  a_r4_oneshot_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && !free_run) |=> $stable(cnt));
endmodule

// File: rtl/match_timer.sv
module match_timer
  import mt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ref_tick,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  mt_cfg_t     cfg;
  logic        run;
  logic        flag;
  logic        wr;
  logic        start_wr, csr_wr, cnt_wr, cmp_wr;
  logic        cnt_pulse, busy, match_evt;
  logic [31:0] cnt, cmp;

  assign wr       = bus_sel && bus_wr;
  assign start_wr = wr && (bus_addr == OFF_START);
  assign csr_wr   = wr && (bus_addr == OFF_CSR);
  assign cnt_wr   = wr && (bus_addr == OFF_COUNT);
  assign cmp_wr   = wr && (bus_addr == OFF_CMP);

  mt_prescaler u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_tick (ref_tick),
    .run      (run),
    .clk_sel  (cfg.clk_sel),
    .cnt_pulse(cnt_pulse)
  );

  mt_counter #(.W(DATA_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_tick (ref_tick),
    .cnt_pulse(cnt_pulse),
    .free_run (cfg.free_run),
    .cnt_wr   (cnt_wr),
    .cmp_wr   (cmp_wr),
    .wdata    (bus_wdata),
    .cnt      (cnt),
    .cmp      (cmp),
    .busy     (busy),
    .match_evt(match_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg  <= '0;
      run  <= 1'b0;
      flag <= 1'b0;
    end else begin
      if (start_wr) run <= bus_wdata[BIT_RUN];
      if (match_evt && !cfg.free_run) run <= 1'b0;
      if (csr_wr) begin
        cfg.free_run <= bus_wdata[BIT_FREE];
        cfg.irq_en   <= bus_wdata[BIT_IE];
        cfg.clk_sel  <= bus_wdata[2:0];
        if (!bus_wdata[BIT_FLAG]) flag <= 1'b0;
      end
      if (match_evt) flag <= 1'b1;
    end
  end

  assign irq = flag && cfg.irq_en;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFF_START: bus_rdata[BIT_RUN] = run;
      OFF_CSR: begin
        bus_rdata[BIT_FLAG] = flag;
        bus_rdata[BIT_BUSY] = busy;
        bus_rdata[BIT_FREE] = cfg.free_run;
        bus_rdata[BIT_IE]   = cfg.irq_en;
        bus_rdata[2:0]      = cfg.clk_sel;
      end
      OFF_COUNT: bus_rdata = cnt;
      OFF_CMP:   bus_rdata = cmp;
      default:   bus_rdata = '0;
    endcase
  end

  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !csr_wr) |=> flag);
  a_r4_oneshot_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && !cfg.free_run) |=> (!run && flag));
  a_r5_free_keeps_run: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && cfg.free_run && !start_wr) |=> run);
endmodule

// File: tb/match_timer_tb.sv
module match_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  match_timer u_dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic tick();
    @(negedge clk);
    ref_tick = 1'b1;
    @(negedge clk);
    ref_tick = 1'b0;
  endtask

  function automatic int divisor(input int sel);
    case (sel)
      1: return 4;
      2: return 8;
      3: return 128;
      4: return 256;
      5: return 32;
      default: return 1;
    endcase
  endfunction

  task automatic load_cnt(input logic [31:0] v);
    wr(8'h64, v);
    tick();
    tick();
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R1 watchdog actual=timeout expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h00, d); chk("R1", "start", d, 0);
    rd(8'h60, d); chk("R1", "csr", d, 0);
    rd(8'h64, d); chk("R1", "count", d, 0);
    rd(8'h68, d); chk("R1", "cmp", d, 0);
    chk("R1", "irq", {31'd0, irq}, 0);

    // R9 compare readback and unused offset
    wr(8'h68, 32'hA5C3_0F01); rd(8'h68, d); chk("R9", "cmp readback", d, 32'hA5C3_0F01);
    rd(8'h40, d); chk("R9", "unused offset", d, 0);

    // R8 busy bit across two reference ticks
    wr(8'h64, 32'd9);
    rd(8'h60, d); chk("R8", "busy after write", {31'd0, d[13]}, 1);
    tick();
    rd(8'h60, d); chk("R8", "busy after one tick", {31'd0, d[13]}, 1);
    rd(8'h64, d); chk("R8", "count not yet loaded", d, 0);
    tick();
    rd(8'h60, d); chk("R8", "busy after two ticks", {31'd0, d[13]}, 0);
    rd(8'h64, d); chk("R8", "count loaded", d, 9);

    // R3 R4 sweep over divisor codes and compare values in one-shot mode
    for (int sel = 0; sel < 8; sel++) begin
      for (int c = 0; c < 3; c++) begin
        int cmpv;
        int dv;
        int n;
        cmpv = (c == 2) ? 3 : c;
        dv = divisor(sel);
        n = dv * (cmpv + 1);
        wr(8'h60, sel);
        wr(8'h68, cmpv);
        load_cnt(0);
        wr(8'h00, 32'h20);
        for (int t = 0; t < n - 1; t++) tick();
        rd(8'h64, d); chk("R3", $sformatf("count sel=%0d cmp=%0d", sel, cmpv), d, (n - 1) / dv);
        rd(8'h60, d); chk("R4", "no flag before match", {31'd0, d[15]}, 0);
        tick();
        rd(8'h60, d); chk("R4", $sformatf("flag sel=%0d cmp=%0d", sel, cmpv), {31'd0, d[15]}, 1);
        rd(8'h00, d); chk("R4", "one-shot clears run", d, 0);
        rd(8'h64, d); chk("R4", "one-shot holds count", d, cmpv);
        tick();
        rd(8'h64, d); chk("R4", "held after extra tick", d, cmpv);
        // R6 write 1 keeps flag, write 0 clears it
        wr(8'h60, 32'h8000 | sel);
        rd(8'h60, d); chk("R6", "write 1 keeps flag", {31'd0, d[15]}, 1);
        wr(8'h60, sel);
        rd(8'h60, d); chk("R6", "write 0 clears flag", {31'd0, d[15]}, 0);
      end
    end

    // R5 free-running wrap, divide by 1, compare 2
    wr(8'h60, 32'h100);
    wr(8'h68, 2);
    load_cnt(0);
    wr(8'h00, 32'h20);
    tick(); tick();
    rd(8'h64, d); chk("R5", "count before wrap", d, 2);
    tick();
    rd(8'h64, d); chk("R5", "wrapped to zero", d, 0);
    rd(8'h60, d); chk("R5", "flag on wrap", {31'd0, d[15]}, 1);
    rd(8'h00, d); chk("R5", "run stays set", d, 32'h20);
    tick();
    rd(8'h64, d); chk("R5", "counting on", d, 1);

    // R7 interrupt follows flag and enable
    chk("R7", "irq off without enable", {31'd0, irq}, 0);
    wr(8'h60, 32'h8110);
    @(negedge clk); chk("R7", "irq with flag and enable", {31'd0, irq}, 1);
    wr(8'h60, 32'h0110);
    @(negedge clk); chk("R7", "irq after clear", {31'd0, irq}, 0);

    // R2 stop holds the counter
    wr(8'h00, 0);
    rd(8'h64, d); chk("R2", "count at stop", d, 1);
    tick(); tick(); tick();
    rd(8'h64, d); chk("R2", "count holds while stopped", d, 1);
    rd(8'h60, d); chk("R2", "no flag while stopped", {31'd0, d[15]}, 0);

    // R8 counter frozen while a write is pending, even when running
    wr(8'h60, 32'h100);
    wr(8'h68, 1000);
    wr(8'h00, 32'h20);
    tick();
    rd(8'h64, d); chk("R2", "count resumes", d, 2);
    wr(8'h64, 50);
    tick();
    rd(8'h64, d); chk("R8", "frozen while pending", d, 2);
    tick();
    rd(8'h64, d); chk("R8", "loaded on second tick", d, 50);
    tick();
    rd(8'h64, d); chk("R8", "counts after load", d, 51);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule